// File: doc/BRIEF.md
# Tamper Timestamp Capture

This block keeps an independent history for each of several tamper input channels. When a channel's tamper line rises, the block records the current calendar time and date, counts the event and remembers whether the system was running in backup mode at that moment. Each channel holds two stamps. The *opening* stamp is frozen at the first event after the channel was last acknowledged. The *latest* stamp is rewritten on every event.

Software reads the stamps through a simple read port with one cycle of latency. Reading a channel's latest-date word acknowledges that channel. The acknowledgement zeroes the channel's event counter and its backup-mode flag, and it re-arms the opening stamp so the next event can fill it. A nonzero counter tells software that the stamps of that channel hold valid data.

The time and date come from a calendar counter outside this block. The tamper lines are assumed to be filtered already. While the calendar runs in its UTC representation, the block leaves all history untouched.

Top module: `tmpr_stamp_unit`

## Requirements
- R1: After reset every mapped register reads 0x00000000.
- R2: The opening time and date stamps of a channel take the calendar values at the first event after reset or after an acknowledgement, and later events leave them unchanged until the next acknowledgement.
- R3: The latest time and date stamps of a channel take the calendar values at every event.
- R4: The event counter sits in bits 27:24 of the opening-time word. It goes up by one per event and holds at 15.
- R5: Bit 31 of the opening-time word reports the value of backup_i at the event that filled the opening stamp.
- R6: A read at channel offset +0xC (latest date) returns the value held before the read and then clears that channel's counter and backup bit. The stamps themselves are kept.
- R7: An event in the same cycle as the acknowledging read counts as the first event after the clear: the counter becomes 1 and both stamps take the current calendar values.
- R8: While utc_mode_i is 1, tamper events change no counter, flag or stamp.
- R9: Channel c occupies byte addresses 0x40 + c*0x10 + {0x0 opening time, 0x4 opening date, 0x8 latest time, 0xC latest date}. Time words place seconds in bits 6:0, minutes in 14:8, hours in 21:16 and the AM/PM flag in bit 22. Every other time bit reads 0, and only the opening-time word carries bits 31 and 27:24.
- R10: rd_data_o shows the addressed word in the cycle after rd_en_i. It is zero after a cycle without rd_en_i, and it is zero for unmapped or non-word-aligned addresses.
- R11: Each tamper input passes through a two-stage synchronizer. Only its rising edge counts, so a level held high for several cycles is a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_i | input | NUM_CH | Filtered tamper lines, one per channel |
| utc_mode_i | input | 1 | Calendar in UTC representation; capture suspended |
| backup_i | input | 1 | System currently in backup mode |
| cal_time_i | input | 32 | Current time in the time-word layout |
| cal_date_i | input | 32 | Current date word |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |

## Verification
The assertions assume that the per-channel event pulse and the acknowledge vector come from the block's own synchronizer and decoder. They also assume that at most one channel is acknowledged per cycle, which follows from a single read address. The counter properties also assume that utc_mode_i and the event pulse are sampled at the same edge as the state update. The stimulus keeps the calendar and backup inputs stable from the moment a tamper line rises until the capture edge has passed. It holds each tamper line high and then low for three cycles, so every rise is one clean event. The only read that overlaps a capture is the one placed deliberately on the capture edge.

// File: rtl/tmpr_stamp_pkg.sv
package tmpr_stamp_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CNT_W      = 4;
  localparam int unsigned TM_BITS    = 21;
  localparam int unsigned SLOT_BYTES = 4;
  localparam int unsigned NUM_SLOTS  = 4;
  localparam int unsigned CH_STRIDE  = SLOT_BYTES * NUM_SLOTS;

  typedef enum logic [1:0] {
    SLOT_OPEN_TIME = 2'd0,
    SLOT_OPEN_DATE = 2'd1,
    SLOT_LAST_TIME = 2'd2,
    SLOT_LAST_DATE = 2'd3
  } slot_e;

  typedef struct packed {
    logic [TM_BITS-1:0] tm;
    logic [DATA_W-1:0]  dt;
  } stamp_t;

  function automatic logic [TM_BITS-1:0] pack_time(input logic [DATA_W-1:0] w);
    return {w[22], w[21:16], w[14:8], w[6:0]};
  endfunction

  function automatic logic [DATA_W-1:0] unpack_time(input logic [TM_BITS-1:0] t);
    return {9'b0, t[20], t[19:14], 1'b0, t[13:7], 1'b0, t[6:0]};
  endfunction

endpackage

// File: rtl/tmpr_sync_edge.sv
module tmpr_sync_edge #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] lvl_i,
  output logic [NUM_CH-1:0] rise_o
);

  logic [NUM_CH-1:0] meta_q;
  logic [NUM_CH-1:0] sync_q;
  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= lvl_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise_o = sync_q & ~prev_q;
  end

endmodule

// File: rtl/tmpr_chan.sv
module tmpr_chan
  import tmpr_stamp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_i,
  input  logic                  cap_en_i,
  input  logic                  ack_i,
  input  logic [TM_BITS-1:0]    now_tm_i,
  input  logic [DATA_W-1:0]     now_dt_i,
  input  logic                  bkup_i,
  output stamp_t                open_o,
  output stamp_t                last_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  bkup_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  stamp_t           open_q, open_d;
  stamp_t           last_q, last_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             bk_q, bk_d, bk_base;
  logic             hit;
  logic             open_we, last_we, stat_we;

  always_comb begin
    hit      = evt_i & cap_en_i;
    cnt_base = ack_i ? '0 : cnt_q;
    bk_base  = ack_i ? 1'b0 : bk_q;

    open_we  = hit && (cnt_base == '0);
    last_we  = hit;
    stat_we  = hit | ack_i;

    open_d   = '{tm: now_tm_i, dt: now_dt_i};
    last_d   = '{tm: now_tm_i, dt: now_dt_i};

    cnt_d    = cnt_base;
    bk_d     = bk_base;
    if (hit) begin
      if (cnt_base != CNT_MAX) begin
        cnt_d = cnt_base + 1'b1;
      end
      if (cnt_base == '0) begin
        bk_d = bkup_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
    end else if (open_we) begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_we) begin
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bk_q  <= 1'b0;
    end else if (stat_we) begin
      cnt_q <= cnt_d;
      bk_q  <= bk_d;
    end
  end

  always_comb begin
    open_o = open_q;
    last_o = last_q;
    cnt_o  = cnt_q;
    bkup_o = bk_q;
  end

endmodule

// File: rtl/tmpr_rd_mux.sv
module tmpr_rd_mux
  import tmpr_stamp_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 64
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    rd_en_i,
  input  logic [ADDR_W-1:0]                       rd_addr_i,
  input  logic [NUM_CH-1:0][NUM_SLOTS-1:0][DATA_W-1:0] words_i,
  output logic [NUM_CH-1:0]                       ack_o,
  output logic [DATA_W-1:0]                       rd_data_o
);

  localparam int unsigned OFF_W    = ADDR_W + 1;
  localparam int unsigned SLOT_LSB = $clog2(SLOT_BYTES);
  localparam int unsigned CH_LSB   = $clog2(CH_STRIDE);
  localparam logic [OFF_W-1:0] BASE_O = OFF_W'(BASE_ADDR);
  localparam logic [OFF_W-1:0] SPAN_O = OFF_W'(NUM_CH * CH_STRIDE);

  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  ch_idx;
  logic [1:0]        slot;
  logic              in_range;
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    off      = {1'b0, rd_addr_i} - BASE_O;
    ch_idx   = off >> CH_LSB;
    slot     = off[SLOT_LSB +: 2];
    in_range = !off[OFF_W-1] && (off < SPAN_O) && (off[SLOT_LSB-1:0] == '0);
  end

  always_comb begin
    sel_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == OFF_W'(c)) begin
        sel_word = words_i[c][slot];
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
    always_comb begin
      ack_o[g] = rd_en_i && in_range && (ch_idx == OFF_W'(g)) &&
                 (slot == SLOT_LAST_DATE);
    end
  end

  always_comb begin
    data_d = (rd_en_i && in_range) ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  always_comb begin
    rd_data_o = data_q;
  end

endmodule

// File: rtl/tmpr_stamp_unit.sv
module tmpr_stamp_unit
  import tmpr_stamp_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tamper_i,
  input  logic              utc_mode_i,
  input  logic              backup_i,
  input  logic [31:0]       cal_time_i,
  input  logic [31:0]       cal_date_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o
);

  logic [NUM_CH-1:0]                            evt_w;
  logic [NUM_CH-1:0]                            ack_w;
  logic [NUM_CH-1:0][CNT_W-1:0]                 cnt_w;
  logic [NUM_CH-1:0][NUM_SLOTS-1:0][DATA_W-1:0] words_w;
  logic [TM_BITS-1:0]                           now_tm;
  logic                                         cap_en;
  logic                                         unused_time_bits;

  always_comb begin
    now_tm           = pack_time(cal_time_i);
    cap_en           = !utc_mode_i;
    unused_time_bits = ^{cal_time_i[31:23], cal_time_i[15], cal_time_i[7]};
  end

  tmpr_sync_edge #(.NUM_CH(NUM_CH)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (tamper_i),
    .rise_o (evt_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    stamp_t open_s, last_s;
    logic   bk_s;

    tmpr_chan chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_w[g]),
      .cap_en_i (cap_en),
      .ack_i    (ack_w[g]),
      .now_tm_i (now_tm),
      .now_dt_i (cal_date_i),
      .bkup_i   (backup_i),
      .open_o   (open_s),
      .last_o   (last_s),
      .cnt_o    (cnt_w[g]),
      .bkup_o   (bk_s)
    );

    always_comb begin
      words_w[g][SLOT_OPEN_TIME] = unpack_time(open_s.tm) |
                                   {bk_s, 3'b000, cnt_w[g], 24'h000000};
      words_w[g][SLOT_OPEN_DATE] = open_s.dt;
      words_w[g][SLOT_LAST_TIME] = unpack_time(last_s.tm);
      words_w[g][SLOT_LAST_DATE] = last_s.dt;
    end
  end

  tmpr_rd_mux #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .words_i   (words_w),
    .ack_o     (ack_w),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/tmpr_stamp_chk.sv
module tmpr_stamp_chk #(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         utc_mode_i,
  input logic                         rd_en_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [31:0]                  rd_data_o,
  input logic [NUM_CH-1:0]            evt,
  input logic [NUM_CH-1:0]            ack,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam int unsigned      OW   = ADDR_W + 1;

  logic [OW-1:0] c_off;
  logic          c_mapped;

  always_comb begin
    c_off    = {1'b0, rd_addr_i} - OW'(BASE_ADDR);
    c_mapped = !c_off[OW-1] && (c_off < OW'(NUM_CH * 16)) && (rd_addr_i[1:0] == 2'b00);
  end

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (rd_data_o == 32'h0)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !c_mapped) |=> (rd_data_o == 32'h0)); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && !utc_mode_i && !ack[g] && cnt[g] != CMAX)
        |=> (cnt[g] == CNT_W'($past(cnt[g]) + 1'b1))); // R4

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CMAX && !ack[g]) |=> (cnt[g] == CMAX)); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !(evt[g] && !utc_mode_i)) |=> (cnt[g] == '0)); // R6

    AST_ACK_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && evt[g] && !utc_mode_i) |=> (cnt[g] == CNT_W'(1))); // R7

    AST_UTC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (utc_mode_i && !ack[g]) |=> $stable(cnt[g])); // R8
  end

endmodule

bind tmpr_stamp_unit tmpr_stamp_chk #(
  .NUM_CH    (NUM_CH),
  .CNT_W     (tmpr_stamp_pkg::CNT_W),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .utc_mode_i (utc_mode_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .evt        (evt_w),
  .ack        (ack_w),
  .cnt        (cnt_w)
);

// File: tb/tmpr_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module tmpr_stamp_unit_tb_top;

  localparam int NCH  = 5;
  localparam int AW   = 8;
  localparam logic [31:0] TMASK = 32'h007F_7F7F;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] tamper;
  logic           utc_mode;
  logic           backup;
  logic [31:0]    cal_time;
  logic [31:0]    cal_date;
  logic           rd_en;
  logic [AW-1:0]  rd_addr;
  logic [31:0]    rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] m_ot[NCH], m_od[NCH], m_lt[NCH], m_ld[NCH];
  int          m_cnt[NCH];
  logic        m_bk[NCH];

  tmpr_stamp_unit #(.NUM_CH(NCH), .ADDR_W(AW), .BASE_ADDR(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper), .utc_mode_i(utc_mode),
    .backup_i(backup), .cal_time_i(cal_time), .cal_date_i(cal_date),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_word(input int a);
    int ch, sl;
    if (a < 64 || a >= 64 + NCH*16 || (a % 4) != 0) return 32'h0;
    ch = (a - 64) / 16;
    sl = ((a - 64) % 16) / 4;
    case (sl)
      0: return m_ot[ch] | {m_bk[ch], 3'b000, 4'(m_cnt[ch]), 24'h0};
      1: return m_od[ch];
      2: return m_lt[ch];
      default: return m_ld[ch];
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_ack(input int a);
    int ch;
    if (a >= 64 && a < 64 + NCH*16 && (a % 16) == 12) begin
      ch = (a - 64) / 16;
      m_cnt[ch] = 0;
      m_bk[ch]  = 1'b0;
    end
  endfunction

  function automatic void model_event(input int ch);
    if (utc_mode) return;
    if (m_cnt[ch] == 0) begin
      m_ot[ch] = cal_time & TMASK;
      m_od[ch] = cal_date;
      m_bk[ch] = backup;
    end
    m_lt[ch] = cal_time & TMASK;
    m_ld[ch] = cal_date;
    if (m_cnt[ch] < 15) m_cnt[ch]++;
  endfunction

  task automatic do_read(input int a, input string tag);
    logic [31:0] e;
    e = exp_word(a);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, e);
    model_ack(a);
  endtask

  task automatic fire(input int ch, input logic [31:0] t, input logic [31:0] d, input logic bk);
    @(negedge clk);
    cal_time   = t;
    cal_date   = d;
    backup     = bk;
    tamper[ch] = 1'b1;
    repeat (3) @(negedge clk);
    tamper[ch] = 1'b0;
    model_event(ch);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] t, d;
    rst_n = 1'b0; tamper = '0; utc_mode = 1'b0; backup = 1'b0;
    cal_time = '0; cal_date = '0; rd_en = 1'b0; rd_addr = '0;
    for (int c = 0; c < NCH; c++) begin
      m_ot[c] = 0; m_od[c] = 0; m_lt[c] = 0; m_ld[c] = 0; m_cnt[c] = 0; m_bk[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: full address sweep after reset
    for (int a = 0; a < 256; a++) do_read(a, (a >= 64 && a < 144) ? "R1" : "R10");

    // R10: idle cycle after a read gives zero
    do_read(64 + 12, "R10");
    @(negedge clk);
    check("R10 idle", rd_data, 32'h0);

    // R2 R3 R4 R5 R11: 17 events per channel, saturation and held stamps
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 17; k++) begin
        t = {8'hFF, 8'(k*3 + c) | 8'h80, 8'(k*7 + 1) | 8'h80, 8'(k*5 + c) | 8'h80};
        d = 32'h2000_0000 + c*32'h100 + k;
        fire(c, t, d, 1'(k + c));
        do_read(64 + c*16 + 0, k == 0 ? "R11" : (k >= 15 ? "R4" : "R5"));
        do_read(64 + c*16 + 8, "R3");
      end
      do_read(64 + c*16 + 4, "R2");
      do_read(64 + c*16 + 12, "R6");
      do_read(64 + c*16 + 0, "R6");
      do_read(64 + c*16 + 4, "R6");
    end

    // R7: event on the same edge as the acknowledging read
    fire(2, 32'h0012_3456, 32'hCAFE_0001, 1'b0);
    @(negedge clk);
    cal_time = 32'h0041_2233; cal_date = 32'hBEEF_0002; backup = 1'b1;
    tamper[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(64 + 2*16 + 12);
    t = exp_word(64 + 2*16 + 12);
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 ack data", rd_data, t);
    model_ack(64 + 2*16 + 12);
    model_event(2);
    tamper[2] = 1'b0;
    repeat (3) @(negedge clk);
    do_read(64 + 2*16 + 0, "R7");
    do_read(64 + 2*16 + 4, "R7");

    // R8: UTC mode suspends capture
    utc_mode = 1'b1;
    fire(4, 32'h0033_3333, 32'h1111_2222, 1'b1);
    utc_mode = 1'b0;
    do_read(64 + 4*16 + 0, "R8");
    do_read(64 + 4*16 + 8, "R8");

    // R9 / R10: full map sweep with live history
    for (int c = 0; c < NCH; c++) fire(c, 32'hFF7F_FF7F ^ c, 32'h5A00_0000 + c, 1'(c));
    for (int a = 0; a < 256; a++) do_read(a, (a >= 64 && a < 144) ? "R9" : "R10");

    done = 1;
    finish_run();
  end

endmodule